// File: doc/BRIEF.md
# Single-Line NMI Interrupt Controller

This block watches one external non-maskable interrupt line and turns it into a registered interrupt request for the main interrupt controller. The line is first brought into the clock domain by a two-flop synchroniser. A two-bit trigger field then chooses how an event is detected: a low or high level, or a falling or rising edge. A detected event sets a pending flag. An enable bit gates that flag onto the request output.

Software reaches the block through a flat 32-bit register port: an address, a write strobe, write data and combinational read data. Writes are single-cycle. Three registers are visible. The trigger register holds the mode. The status register shows the pending flag, and writing a 1 to its bit 0 clears the flag. The gate register holds the enable bit. A parameter selects between two fixed address layouts, so the same block can serve either register map.

Top module: `nmi_line_ctrl`

## Requirements
- R1: After a synchronous reset, the trigger field reads 0 (low level), the enable bit reads 0, the pending flag reads 0 and `irq_out` is 0.
- R2: The trigger field is bits [1:0] of the trigger register. Its codes are 0 = low level, 1 = falling edge, 2 = high level and 3 = rising edge. A change on `nmi_in` just before clock edge k reaches the pending flag at edge k+2, because it first passes a two-flop synchroniser.
- R3: In an edge mode, a matching edge sets pending, and pending stays set until software writes 1 to bit 0 of the status register. An edge of the opposite direction sets nothing.
- R4: In a level mode, pending follows whether the synchronised line is at its active level. An acknowledge written while the line is still active leaves pending at 1.
- R5: In an edge mode, if a matching edge is detected in the same cycle as an acknowledge write, pending stays 1.
- R6: `irq_out` is a register that holds the pending flag ANDed with enable bit 0. While enable is 0, `irq_out` stays 0 even when pending is 1.
- R7: A trigger-register write that changes the mode restarts the edge history. Switching modes on a steady line therefore never sets pending in an edge mode.
- R8: Register bits that are not defined read as 0, and writes to them are ignored. A write to an unmapped address changes no register, and a read from an unmapped address returns 0.
- R9: With `ALT_LAYOUT`=0, the trigger, status and gate registers are at offsets 0x00, 0x04 and 0x08. With `ALT_LAYOUT`=1, they are at offsets 0x0C, 0x10 and 0x40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_in | input | 1 | Asynchronous external interrupt line |
| bus_addr | input | ADDR_W (8) | Register byte offset |
| bus_we | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Combinational read data for `bus_addr` |
| irq_out | output | 1 | Registered interrupt request |

## Verification
Two functions can land in the same cycle: a newly detected edge setting pending, and a software acknowledge clearing it. The bench provokes this in rising-edge mode. It raises the line and times the status-register write so that the write is sampled at exactly the clock edge where the synchronised edge reaches the pending logic, which is two edges after the input change. It judges the result by reading the status register afterwards: the flag must still be 1. A plain acknowledge that follows must then clear it.

// File: rtl/nmi_line_pkg.sv
// Shared trigger-mode type for the single-line interrupt controller.
// The encoding is chosen so that bit 0 means "edge" and bit 1 means
// "active high"; the detector decodes those two bits directly.
package nmi_line_pkg;

    typedef enum logic [1:0] {
        TRIG_LOW_LEVEL  = 2'd0,
        TRIG_FALL_EDGE  = 2'd1,
        TRIG_HIGH_LEVEL = 2'd2,
        TRIG_RISE_EDGE  = 2'd3
    } trig_e;

    // True when the mode detects transitions rather than levels.
    function automatic logic trig_is_edge(input trig_e m);
        return m[0];
    endfunction

    // True when the mode treats a high line as active.
    function automatic logic trig_is_high(input trig_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/nmi_sync.sv
// Multi-flop synchroniser for one asynchronous line.
// Assumes: the input is held for at least one clock period around each
// change; the reset value matches the line's idle level.
module nmi_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift the line one flop further along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q[s] <= RST_VAL;
                end else if (s == 0) begin
                    chain_q[s] <= async_in;
                end else begin
                    chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/nmi_detect.sv
// Event detector and pending flag.
// Level modes: pending tracks the active level every cycle.
// Edge modes: a matching edge sets pending; an acknowledge clears it unless
// a new edge arrives in the same cycle. A restart pulse reloads the edge
// history and masks detection for that cycle.
// Assumes: sample is already synchronous to clk.
module nmi_detect
    import nmi_line_pkg::*;
#(
    parameter logic RST_VAL = 1'b1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sample,
    input  trig_e mode,
    input  logic  restart,
    input  logic  ack,
    output logic  pending
);
    logic hist_q;
    logic pend_q;
    logic active_lvl;
    logic edge_hit;

    // Decide whether the current sample is an event for the active mode.
    always_comb begin
        active_lvl = trig_is_high(mode) ? sample : ~sample;
        if (trig_is_high(mode)) begin
            edge_hit = sample & ~hist_q & ~restart;
        end else begin
            edge_hit = ~sample & hist_q & ~restart;
        end
    end

    // Keep the previous synchronised sample for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= RST_VAL;
        end else begin
            hist_q <= sample;
        end
    end

    // Update the pending flag according to the mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (trig_is_edge(mode)) begin
            pend_q <= edge_hit | (pend_q & ~ack);
        end else begin
            pend_q <= active_lvl;
        end
    end

    assign pending = pend_q;
endmodule

// File: rtl/nmi_regs.sv
// Register port: trigger, status and gate registers at one of two layouts.
// Produces the acknowledge and restart pulses for the detector.
// Assumes: single-cycle writes; reads are combinational on the address.
module nmi_regs
    import nmi_line_pkg::*;
#(
    parameter bit ALT_LAYOUT = 1'b0,
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pending,
    output trig_e             mode,
    output logic              enable,
    output logic              ack,
    output logic              restart,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [ADDR_W-1:0] OFF_TRIG = ALT_LAYOUT ? ADDR_W'(8'h0C) : ADDR_W'(8'h00);
    localparam logic [ADDR_W-1:0] OFF_STAT = ALT_LAYOUT ? ADDR_W'(8'h10) : ADDR_W'(8'h04);
    localparam logic [ADDR_W-1:0] OFF_GATE = ALT_LAYOUT ? ADDR_W'(8'h40) : ADDR_W'(8'h08);

    trig_e mode_q;
    logic  en_q;
    logic  sel_trig, sel_stat, sel_gate;
    logic  trig_wr;

    // Decode the address and form the write pulses.
    always_comb begin
        sel_trig = (addr == OFF_TRIG);
        sel_stat = (addr == OFF_STAT);
        sel_gate = (addr == OFF_GATE);
        trig_wr  = we & sel_trig;
        ack      = we & sel_stat & wdata[0];
        restart  = trig_wr & (trig_e'(wdata[1:0]) != mode_q);
    end

    // Hold the trigger mode and the enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= TRIG_LOW_LEVEL;
            en_q   <= 1'b0;
        end else begin
            if (trig_wr) begin
                mode_q <= trig_e'(wdata[1:0]);
            end
            if (we && sel_gate) begin
                en_q <= wdata[0];
            end
        end
    end

    // Return the selected register, zero-extended.
    always_comb begin
        rdata = '0;
        if (sel_trig) begin
            rdata[1:0] = mode_q;
        end else if (sel_stat) begin
            rdata[0] = pending;
        end else if (sel_gate) begin
            rdata[0] = en_q;
        end
    end

    assign mode   = mode_q;
    assign enable = en_q;
endmodule

// File: rtl/nmi_line_ctrl.sv
// Top of the single-line interrupt controller: synchroniser, detector,
// register port and the registered request output.
// Assumes: nmi_in idles high (the reset mode is low level).
module nmi_line_ctrl
    import nmi_line_pkg::*;
#(
    parameter bit ALT_LAYOUT  = 1'b0,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);
    localparam logic IDLE_LVL = 1'b1;

    logic  line_s;
    trig_e mode_q;
    logic  enable_q;
    logic  pending_q;
    logic  ack_pulse;
    logic  restart_pulse;
    logic  irq_q;

    nmi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(IDLE_LVL)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(nmi_in), .sync_out(line_s)
    );

    nmi_regs #(.ALT_LAYOUT(ALT_LAYOUT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we),
        .wdata(bus_wdata), .pending(pending_q), .mode(mode_q),
        .enable(enable_q), .ack(ack_pulse), .restart(restart_pulse),
        .rdata(bus_rdata)
    );

    nmi_detect #(.RST_VAL(IDLE_LVL)) u_det (
        .clk(clk), .rst_n(rst_n), .sample(line_s), .mode(mode_q),
        .restart(restart_pulse), .ack(ack_pulse), .pending(pending_q)
    );

    // Register the gated request toward the main interrupt controller.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= pending_q & enable_q;
        end
    end

    assign irq_out = irq_q;
endmodule

// File: rtl/nmi_line_ctrl_chk.sv
// Assertion checker for nmi_line_ctrl, attached with bind.
module nmi_line_ctrl_chk
    import nmi_line_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input trig_e             mode,
    input logic              enable,
    input logic              pending,
    input logic              ack,
    input logic              restart,
    input logic              irq_out,
    input logic [DATA_W-1:0] rdata
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (mode == TRIG_LOW_LEVEL && !enable && !pending && !irq_out));

    // R6
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && enable) |=> irq_out);

    // R6
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pending && enable) |=> !irq_out);

    // R3
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_is_edge(mode) && pending && !ack && !restart) |=> pending);

    // R8
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[DATA_W-1:2] == '0);
endmodule

bind nmi_line_ctrl nmi_line_ctrl_chk #(.DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .enable(enable_q),
    .pending(pending_q), .ack(ack_pulse), .restart(restart_pulse),
    .irq_out(irq_out), .rdata(bus_rdata)
);

// File: tb/nmi_line_ctrl_tb_top.sv
module nmi_line_ctrl_tb_top;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam logic [7:0] A_TRIG = 8'h00, A_STAT = 8'h04, A_GATE = 8'h08;
    localparam int NVEC = 8;
    // {mode, line before, line after, expected pending}
    localparam logic [4:0] VEC [NVEC] = '{
        {2'd0, 1'b1, 1'b0, 1'b1}, {2'd0, 1'b0, 1'b1, 1'b0},
        {2'd1, 1'b1, 1'b0, 1'b1}, {2'd1, 1'b0, 1'b1, 1'b0},
        {2'd2, 1'b0, 1'b1, 1'b1}, {2'd2, 1'b1, 1'b0, 1'b0},
        {2'd3, 1'b0, 1'b1, 1'b1}, {2'd3, 1'b1, 1'b0, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              nmi_in = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata, alt_rdata, rdv;
    logic              irq_out, alt_irq;
    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    nmi_line_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    nmi_line_ctrl #(.ALT_LAYOUT(1'b1)) dut_alt_i (
        .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(alt_rdata),
        .irq_out(alt_irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        bus_addr = a;
        #1 rdv = bus_rdata;
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(1);
        // R1 reset state
        rd(A_TRIG); chk("R1 trig", rdv, 0);
        rd(A_GATE); chk("R1 gate", rdv, 0);
        rd(A_STAT); chk("R1 pend", rdv, 0);
        chk("R1 irq", irq_out, 0);

        // R6 gate closed: low level active, pending 1 but no request
        nmi_in = 1'b0; wait_cyc(6);
        rd(A_STAT); chk("R6 pend", rdv, 1);
        chk("R6 irq gated", irq_out, 0);
        // R4 ack while active keeps pending
        wr(A_STAT, 1); wait_cyc(2);
        rd(A_STAT); chk("R4 ack held", rdv, 1);
        // R8 unused bits
        wr(A_GATE, 32'hFFFF_FFFF); wait_cyc(2);
        rd(A_GATE); chk("R8 gate bits", rdv, 1);
        chk("R6 irq open", irq_out, 1);

        // R2 R3 R4 vector walk
        for (int i = 0; i < NVEC; i++) begin
            nmi_in = VEC[i][2]; wait_cyc(6);
            wr(A_TRIG, {30'h3FFF_FFFF, VEC[i][4:3]}); wait_cyc(3);
            wr(A_STAT, 1); wait_cyc(3);
            nmi_in = VEC[i][1]; wait_cyc(6);
            rd(A_TRIG); chk("R2 mode rb", rdv, {30'd0, VEC[i][4:3]});
            rd(A_STAT); chk("R2 R3 R4 pend", rdv, {31'd0, VEC[i][0]});
            chk("R6 irq vec", irq_out, VEC[i][0]);
        end

        // R5 edge coinciding with ack (rising mode)
        wr(A_TRIG, 3); nmi_in = 1'b0; wait_cyc(6);
        nmi_in = 1'b1; wait_cyc(6);
        rd(A_STAT); chk("R3 set", rdv, 1);
        nmi_in = 1'b0; wait_cyc(6);
        rd(A_STAT); chk("R3 held", rdv, 1);
        nmi_in = 1'b1;
        @(negedge clk);
        wr(A_STAT, 1); wait_cyc(1);
        rd(A_STAT); chk("R5 collide", rdv, 1);
        wr(A_STAT, 1); wait_cyc(1);
        rd(A_STAT); chk("R3 cleared", rdv, 0);

        // R7 mode change on steady high line
        wr(A_TRIG, 1); wait_cyc(3);
        wr(A_STAT, 1); wait_cyc(2);
        wr(A_TRIG, 3); wait_cyc(4);
        rd(A_STAT); chk("R7 no false edge", rdv, 0);

        // R8 R9 layouts
        wr(8'h0C, 2); wait_cyc(1);
        rd(A_TRIG); chk("R8 unmapped write", rdv, 3);
        rd(8'h0C); chk("R8 unmapped read", rdv, 0);
        bus_addr = 8'h0C; #1 chk("R9 alt trig", alt_rdata, 2);
        wr(8'h40, 1); wait_cyc(1);
        bus_addr = 8'h40; #1 chk("R9 alt gate", alt_rdata, 1);
        bus_addr = 8'h00; #1 chk("R9 alt off0", alt_rdata, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule